// File: doc/BRIEF.md
# Register-or-Immediate Operate Unit

This block executes the three operate instructions of a 16-bit, eight-register machine: addition, bitwise AND and bitwise complement. An instruction word arrives on a valid/ready input channel. While the word is offered, the block drives two read addresses toward an external register file and takes the two read values back in the same cycle. On acceptance it decodes the word, forms the second operand from either a register or a sign-extended 5-bit literal, computes the result and its sign class, and registers one result beat on a valid/ready output channel.

Every accepted word yields exactly one output beat. The beat carries a write enable, a destination index, the write-back value, three condition flags and an illegal-encoding flag. Words that are not operate instructions pass through as beats with the write enable low, so that a downstream sequencer stays in step. Back-pressure is handled by a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the beat is held unchanged and no new word is taken.

Top module: `opu_top`

## Requirements
- R1: The opcode is bits 15–12 of the word: 0001 is add, 0101 is AND and 1001 is complement. Any other opcode gives a beat with `out_wr_en`=0, `out_illegal`=0, `out_cc`=000 and `out_value`=0.
- R2: While a word is offered, `rd_addr_a` equals bits 8–6 and `rd_addr_b` equals bits 2–0, combinationally. `out_dest` of the resulting beat equals bits 11–9.
- R3: For add and AND, bit 5 = 0 selects register mode, and the second operand is `rd_data_b`.
- R4: For add and AND, bit 5 = 1 selects immediate mode. The second operand is bits 4–0, read as a two's-complement number (−16..+15) and sign-extended to 16 bits.
- R5: Add produces `rd_data_a` plus the operand, modulo 2^16, with no carry or overflow output.
- R6: AND produces the bitwise AND of `rd_data_a` and the operand.
- R7: Complement produces the bitwise inverse of `rd_data_a`. If bits 5–0 of a complement word are not 111111, the beat has `out_illegal`=1, `out_wr_en`=0, `out_value`=0 and `out_cc`=000.
- R8: In register mode, bits 4–3 must be 00. A nonzero value gives `out_illegal`=1, `out_wr_en`=0, `out_value`=0 and `out_cc`=000. In immediate mode these bits belong to the literal and are never flagged.
- R9: A beat with `out_wr_en`=1 has exactly one flag set in `out_cc`, judged from `out_value` read as a signed number: bit 2 means negative, bit 1 means zero and bit 0 means positive. A beat with `out_wr_en`=0 has `out_cc`=000.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, every output holds its value.
- R11: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is offered |
| in_ready | output | 1 | Block accepts the word this cycle |
| in_instr | input | 16 | Instruction word |
| rd_addr_a | output | 3 | Register file read index, first source |
| rd_addr_b | output | 3 | Register file read index, second source |
| rd_data_a | input | 16 | Read value for `rd_addr_a` |
| rd_data_b | input | 16 | Read value for `rd_addr_b` |
| out_valid | output | 1 | Result beat is present |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_wr_en | output | 1 | Beat should be written to the register file |
| out_dest | output | 3 | Destination register index |
| out_value | output | 16 | Write-back value |
| out_cc | output | 3 | Condition flags {negative, zero, positive} |
| out_illegal | output | 1 | Malformed operate word |

## Verification
The hardest case to reach from the ports is a held beat under back-pressure while a second word is already waiting on the input. The stimulus lowers `out_ready`, offers a word, then offers another word and checks over several cycles that the first beat stays frozen and that `in_ready` stays low. Only after that does it release the consumer and confirm that the waiting word follows. Malformed words, such as a complement with a wrong low pattern or register-mode words with reserved bits set, are never produced by an assembler, so the bench builds them bit by bit. It also sends immediate-mode words whose literal happens to set bits 4–3, to show that these are not flagged.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int IW        = 16;
  localparam int RIDX_W    = 3;
  localparam int LIT_W     = 5;
  localparam logic [3:0] OPC_ADD  = 4'b0001;
  localparam logic [3:0] OPC_AND  = 4'b0101;
  localparam logic [3:0] OPC_NOT  = 4'b1001;
  localparam logic [5:0] NOT_TAIL = 6'b111111;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ADD  = 2'd1,
    K_AND  = 2'd2,
    K_NOT  = 2'd3
  } kind_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_t;
endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [IW-1:0]     instr,
  output kind_e             kind,
  output logic [RIDX_W-1:0] dest,
  output logic [RIDX_W-1:0] src1,
  output logic [RIDX_W-1:0] src2,
  output logic              use_lit,
  output logic [DW-1:0]     lit,
  output logic              illegal
);
  localparam int EXT_W = DW - LIT_W;

  assign dest    = instr[11:9];
  assign src1    = instr[8:6];
  assign src2    = instr[2:0];
  assign use_lit = instr[5];
  assign lit     = {{EXT_W{instr[LIT_W-1]}}, instr[LIT_W-1:0]};

  always_comb begin
    kind    = K_NONE;
    illegal = 1'b0;
    unique case (instr[15:12])
      OPC_ADD: begin
        kind    = K_ADD;
        illegal = !instr[5] && (instr[4:3] != 2'b00);
      end
      OPC_AND: begin
        kind    = K_AND;
        illegal = !instr[5] && (instr[4:3] != 2'b00);
      end
      OPC_NOT: begin
        kind    = K_NOT;
        illegal = (instr[5:0] != NOT_TAIL);
      end
      default: begin
        kind    = K_NONE;
        illegal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/opu_alu.sv
module opu_alu
  import opu_pkg::*;
#(
  parameter int DW = 16
) (
  input  kind_e         kind,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] result
);
  always_comb begin
    unique case (kind)
      K_ADD:   result = opa + opb;
      K_AND:   result = opa & opb;
      K_NOT:   result = ~opa;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/opu_cc.sv
module opu_cc
  import opu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          en,
  input  logic [DW-1:0] value,
  output cc_t           cc
);
  logic is_zero;
  assign is_zero = (value == '0);

  always_comb begin
    cc = '0;
    if (en) begin
      cc.neg  = value[DW-1];
      cc.zero = is_zero;
      cc.pos  = !value[DW-1] && !is_zero;
    end
  end
endmodule

// File: rtl/opu_top.sv
module opu_top
  import opu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IW-1:0]     in_instr,
  output logic [RIDX_W-1:0] rd_addr_a,
  output logic [RIDX_W-1:0] rd_addr_b,
  input  logic [DW-1:0]     rd_data_a,
  input  logic [DW-1:0]     rd_data_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic [RIDX_W-1:0] out_dest,
  output logic [DW-1:0]     out_value,
  output logic [2:0]        out_cc,
  output logic              out_illegal
);
  kind_e             kind;
  logic [RIDX_W-1:0] dest;
  logic              use_lit;
  logic [DW-1:0]     lit;
  logic              bad;
  logic [DW-1:0]     opb;
  logic [DW-1:0]     raw;
  logic              do_wr;
  logic [DW-1:0]     wb_val;
  cc_t               cc;
  logic              take;

  opu_decode #(.DW(DW)) u_dec (
    .instr   (in_instr),
    .kind    (kind),
    .dest    (dest),
    .src1    (rd_addr_a),
    .src2    (rd_addr_b),
    .use_lit (use_lit),
    .lit     (lit),
    .illegal (bad)
  );

  assign opb = use_lit ? lit : rd_data_b;

  opu_alu #(.DW(DW)) u_alu (
    .kind   (kind),
    .opa    (rd_data_a),
    .opb    (opb),
    .result (raw)
  );

  assign do_wr  = (kind != K_NONE) && !bad;
  assign wb_val = do_wr ? raw : '0;

  opu_cc #(.DW(DW)) u_cc (
    .en    (do_wr),
    .value (wb_val),
    .cc    (cc)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_dest    <= '0;
      out_value   <= '0;
      out_cc      <= '0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_wr_en   <= do_wr;
      out_dest    <= dest;
      out_value   <= wb_val;
      out_cc      <= cc;
      out_illegal <= bad;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/opu_chk.sv
module opu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_wr_en,
  input logic [2:0]    out_dest,
  input logic [DW-1:0] out_value,
  input logic [2:0]    out_cc,
  input logic          out_illegal
);
  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_dest)
      && $stable(out_wr_en) && $stable(out_cc) && $stable(out_illegal)));

  assert_cc_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_en) |-> ($countones(out_cc) == 1));

  assert_cc_zero_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_en) |-> (out_cc[1] == (out_value == '0)));

  assert_cc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wr_en) |-> (out_cc == 3'b000));

  assert_illegal_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_wr_en && out_value == '0));
endmodule

bind opu_top opu_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_wr_en   (out_wr_en),
  .out_dest    (out_dest),
  .out_value   (out_value),
  .out_cc      (out_cc),
  .out_illegal (out_illegal)
);

// File: tb/tb_opu_top.sv
`timescale 1ns/1ps
module tb_opu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [2:0]  rd_addr_a, rd_addr_b;
  logic [15:0] rd_data_a, rd_data_b;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_wr_en;
  logic [2:0]  out_dest;
  logic [15:0] out_value;
  logic [2:0]  out_cc;
  logic        out_illegal;

  logic [15:0] regs [8];
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];

  opu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_wr_en(out_wr_en), .out_dest(out_dest),
    .out_value(out_value), .out_cc(out_cc), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected beat computed from the requirement text
  task automatic expect_beat(input string tag, input logic [15:0] w);
    logic [3:0]  op;
    logic [15:0] a, b, v;
    logic        leg, is_op;
    logic [2:0]  cc;
    op    = w[15:12];
    a     = regs[w[8:6]];
    b     = w[5] ? {{11{w[4]}}, w[4:0]} : regs[w[2:0]];
    is_op = (op == 4'b0001) || (op == 4'b0101) || (op == 4'b1001);
    leg   = 1'b0;
    v     = 16'h0;
    if (op == 4'b0001) begin leg = w[5] || (w[4:3] == 2'b00); v = a + b; end
    if (op == 4'b0101) begin leg = w[5] || (w[4:3] == 2'b00); v = a & b; end
    if (op == 4'b1001) begin leg = (w[5:0] == 6'b111111);     v = ~a;    end
    if (!leg) v = 16'h0;
    cc = leg ? {v[15], v == 16'h0, !v[15] && v != 16'h0} : 3'b000;
    chk(tag, "valid",   {31'd0, out_valid},   32'd1);
    chk(tag, "wr_en",   {31'd0, out_wr_en},   {31'd0, leg});
    chk(tag, "illegal", {31'd0, out_illegal}, {31'd0, is_op && !leg});
    chk(tag, "dest",    {29'd0, out_dest},    {29'd0, w[11:9]});
    chk(tag, "value",   {16'd0, out_value},   {16'd0, v});
    chk(tag, "cc",      {29'd0, out_cc},      {29'd0, cc});
  endtask

  task automatic send(input string tag, input logic [15:0] w);
    @(negedge clk);
    in_instr  = w;
    in_valid  = 1'b1;
    out_ready = 1'b1;
    #1;
    chk(tag, "rd_addr_a R2", {29'd0, rd_addr_a}, {29'd0, w[8:6]});
    chk(tag, "rd_addr_b R2", {29'd0, rd_addr_b}, {29'd0, w[2:0]});
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat(tag, w);
  endtask

  task automatic t_reset_R11;
    chk("R11", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11", "in_ready",  {31'd0, in_ready},  32'd1);
  endtask

  task automatic t_register_mode_R3;
    send("R3 add reg",  16'b0001_010_011_000_100);
    send("R6 and reg",  16'b0101_111_001_000_010);
  endtask

  task automatic t_literal_R4;
    send("R4 add -16", 16'b0001_001_000_1_10000);
    send("R4 add +15", 16'b0001_001_000_1_01111);
    send("R4 and lit bits43", 16'b0101_011_100_1_11010);
  endtask

  task automatic t_wrap_R5;
    send("R5 wrap 7FFF+1",  16'b0001_000_101_1_00001);
    send("R5 wrap FFFF+1",  16'b0001_000_110_1_00001);
  endtask

  task automatic t_flags_R9;
    send("R9 zero via and0", 16'b0101_100_010_1_00000);
    send("R9 pos",           16'b0001_100_010_1_00011);
  endtask

  task automatic t_not_R7;
    send("R7 not ok",    16'b1001_110_010_111111);
    send("R7 not bad",   16'b1001_110_010_111110);
    send("R7 not bad2",  16'b1001_110_010_011111);
  endtask

  task automatic t_reserved_R8;
    send("R8 add rsv01", 16'b0001_001_000_0_01_001);
    send("R8 and rsv10", 16'b0101_001_000_0_10_001);
  endtask

  task automatic t_other_R1;
    send("R1 op0000", 16'b0000_011_010_111111);
    send("R1 op1111", 16'b1111_101_001_000001);
    send("R1 op1101", 16'b1101_101_001_111111);
  endtask

  task automatic t_stall_R10;
    logic [15:0] wa, wb;
    wa = 16'b0001_011_001_000_010;
    wb = 16'b0101_010_011_1_01100;
    @(negedge clk);
    out_ready = 1'b0;
    in_instr  = wa;
    in_valid  = 1'b1;
    @(negedge clk);
    in_instr = wb;
    #1;
    chk("R10", "in_ready while stalled", {31'd0, in_ready}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_beat("R10 hold", wa);
      chk("R10", "in_ready hold", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    #1;
    chk("R10", "in_ready on drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat("R10 next", wb);
    @(negedge clk);
    chk("R10", "empty after drain", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    regs[0] = 16'h1234; regs[1] = 16'h00F0; regs[2] = 16'h00FF; regs[3] = 16'h8001;
    regs[4] = 16'h0F0F; regs[5] = 16'h7FFF; regs[6] = 16'hFFFF; regs[7] = 16'h0000;
    #1;
    t_reset_R11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R11;
    t_register_mode_R3;
    t_literal_R4;
    t_wrap_R5;
    t_flags_R9;
    t_not_R7;
    t_reserved_R8;
    t_other_R1;
    t_stall_R10;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule